// File: doc/BRIEF.md
# Streaming Integer Softmax Engine

This block turns one row of signed 8-bit attention scores into an integer approximation of softmax. The row does not arrive all at once. It arrives as a stream of column groups, one group of `GROUP_W` scores per beat. As each group comes in, the engine updates a running row maximum. Whenever that maximum grows, it rescales the running exponent sum it has built so far. It then adds the group's power-of-two exponent contributions, each taken relative to the new maximum.

When the last group of the row has been accepted, a serial divider forms the row's normalisation factor. The engine then replays the buffered scores and emits one group of normalised values per cycle, in the same column order as the input. Every emitted value lies between 0 and 127, so a downstream signed-by-signed dot product can use it directly. Rows are processed one at a time. The row length `SEQ_LEN` must be a multiple of `GROUP_W`.

Top module: `smx_stream_top`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `inReady` is 1 and `outValid` is 0.
- R2: A row is `SEQ_LEN/GROUP_W` accepted beats. A beat is accepted at a rising edge where `inValid` and `inReady` are both 1. Lane `l` (bits `8l+7:8l`) of beat `g` is the two's-complement score of column `g*GROUP_W+l`.
- R3: For a difference `d` in 0..255, define the exponent shift as `esh(d) = floor(d/32) + (1 if d mod 32 >= 16 else 0)`. A score `x` adds `256 >> esh(M-x)` to the row sum, where `M` is the running maximum after its group's update. The addition is 0 when `esh >= 8`.
- R4: The first group of a row sets the running maximum to its own maximum and starts the sum at 0. A later group whose maximum exceeds the running maximum first right-shifts the stored sum by `esh(new-old)` and then raises the maximum. A later group whose maximum is not larger leaves both unchanged before its own contributions are added.
- R5: The row factor is `floor(130048 / S)`, where 130048 is 127·1024 and `S` is the final row sum. The factor is 0 when `S` is 0.
- R6: Each output value is `min(127, factor >> esh(M - x))`, using the row's final maximum `M`. The value is 0 when `esh >= 8`.
- R7: After the edge that accepts the last beat of a row, `inReady` is 0. `outValid` first becomes 1 after the 18th following rising edge. It then stays 1 for exactly `SEQ_LEN/GROUP_W` consecutive cycles, beat `g` carrying columns `g*GROUP_W..g*GROUP_W+GROUP_W-1` in the lane order of R2. After that, `inReady` returns to 1.
- R8: Beats presented while `inReady` is 0 are ignored. They change neither the outputs of the row in progress nor those of the next row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Score group present on `inData` |
| inReady | output | 1 | Engine can take a score group |
| inData | input | GROUP_W*8 | One group of signed 8-bit scores, lane 0 in the low byte |
| outValid | output | 1 | Normalised group present on `outData` |
| outData | output | GROUP_W*8 | One group of output values in 0..127, lane 0 in the low byte |

## Verification
The bench builds the block with its defaults, `GROUP_W` = 16 and `SEQ_LEN` = 64. That gives four groups per row, so a single row can raise its maximum up to three times and exercise the rescale-then-add order of R4 repeatedly. A jump from -128 to 127 produces the full 8-place rescale. The 17-step divider with an 18-cycle busy window is long enough to inject ignored beats, and the rows place differences on both sides of every 16-count rounding boundary.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic [1:0] {
    S_ACCUM  = 2'd0,
    S_DIVIDE = 2'd1,
    S_EMIT   = 2'd2
  } smxState_t;

  typedef struct packed {
    logic accept;   // take a group this cycle
    logic first;    // group is the first of its row
    logic divInit;  // load the divider
    logic divStep;  // one restoring division step
    logic emit;     // present a normalised group
  } smxStrobe_t;

  // Power-of-two exponent shift: d/32 rounded at a remainder of 16.
  function automatic logic [3:0] expShift(input logic [7:0] d);
    return {1'b0, d[7:5]} + {3'b000, d[4]};
  endfunction

endpackage

// File: rtl/smx_ctrl.sv
module smx_ctrl
  import smx_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int QW         = 17,
  parameter int GIDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  output smxStrobe_t        st,
  output logic [GIDX_W-1:0] slot
);

  localparam int MAXC  = (NUM_GROUPS > QW + 1) ? NUM_GROUPS : QW + 1;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  smxState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             lastGroup;
  logic             lastEmit;
  logic             lastStep;

  assign lastGroup = (cnt == CNT_W'(NUM_GROUPS - 1));
  assign lastEmit  = lastGroup;
  assign lastStep  = (cnt == CNT_W'(QW));

  assign inReady  = (state == S_ACCUM);
  assign outValid = (state == S_EMIT);
  assign slot     = GIDX_W'(cnt);

  always_comb begin
    st         = '0;
    st.accept  = (state == S_ACCUM) && inValid;
    st.first   = (cnt == '0);
    st.divInit = (state == S_DIVIDE) && (cnt == '0);
    st.divStep = (state == S_DIVIDE) && (cnt != '0);
    st.emit    = (state == S_EMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_ACCUM;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_ACCUM: if (inValid) begin
          if (lastGroup) begin
            state <= S_DIVIDE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DIVIDE: begin
          if (lastStep) begin
            state <= S_EMIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_EMIT: begin
          if (lastEmit) begin
            state <= S_ACCUM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= S_ACCUM;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R7: the engine stops taking input once a row is complete
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && lastGroup) |=> !inReady);

  // R7: output beats are followed by a return to accepting input
  assert_emit_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && lastEmit) |=> (inReady && !outValid));

endmodule

// File: rtl/smx_datapath.sv
module smx_datapath
  import smx_pkg::*;
#(
  parameter int GROUP_W    = 16,
  parameter int SEQ_LEN    = 64,
  parameter int NUM_GROUPS = 4,
  parameter int SUM_W      = 15,
  parameter int QW         = 17,
  parameter int DIVIDEND   = 130048,
  parameter int OUT_MAX    = 127,
  parameter int GIDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  smxStrobe_t             st,
  input  logic [GIDX_W-1:0]      slot,
  input  logic [GROUP_W*8-1:0]   inData,
  output logic [GROUP_W*8-1:0]   outData
);

  localparam int PW = QW + SUM_W;

  logic signed [7:0]  rowBuf [SEQ_LEN];
  logic signed [7:0]  runMax;
  logic [SUM_W-1:0]   sum;
  logic [SUM_W-1:0]   rem;
  logic [QW-1:0]      quo;

  logic signed [7:0]  laneIn  [GROUP_W];
  logic signed [7:0]  grpMax;
  logic signed [7:0]  newMax;
  logic [3:0]         rescale;
  logic [SUM_W-1:0]   laneC   [GROUP_W];
  logic [SUM_W-1:0]   contrib;
  logic [SUM_W-1:0]   sumNext;
  logic [QW-1:0]      factor;
  logic [SUM_W:0]     trial;

  // ---------------- group accumulation ----------------
  always_comb begin
    for (int l = 0; l < GROUP_W; l++) laneIn[l] = signed'(inData[l*8 +: 8]);
  end

  always_comb begin
    grpMax = laneIn[0];
    for (int l = 1; l < GROUP_W; l++)
      if (laneIn[l] > grpMax) grpMax = laneIn[l];
  end

  always_comb begin
    logic signed [8:0] jump;
    jump    = {grpMax[7], grpMax} - {runMax[7], runMax};
    newMax  = runMax;
    rescale = '0;
    if (st.first) begin
      newMax = grpMax;
    end else if (grpMax > runMax) begin
      newMax  = grpMax;
      rescale = expShift(jump[7:0]);
    end
  end

  always_comb begin
    contrib = '0;
    for (int l = 0; l < GROUP_W; l++) begin
      logic signed [8:0] d;
      logic [3:0]        sh;
      d  = {newMax[7], newMax} - {laneIn[l][7], laneIn[l]};
      sh = expShift(d[7:0]);
      laneC[l] = (sh >= 4'd8) ? '0 : SUM_W'(9'd256 >> sh);
      contrib  = contrib + laneC[l];
    end
    sumNext = (st.first ? '0 : (sum >> rescale)) + contrib;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runMax <= '0;
      sum    <= '0;
    end else if (st.accept) begin
      runMax <= newMax;
      sum    <= sumNext;
    end
  end

  always_ff @(posedge clk) begin
    if (st.accept) begin
      for (int l = 0; l < GROUP_W; l++)
        rowBuf[int'(slot) * GROUP_W + l] <= laneIn[l];
    end
  end

  // ---------------- restoring divider ----------------
  assign trial = {rem, quo[QW-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem <= '0;
      quo <= '0;
    end else if (st.divInit) begin
      rem <= '0;
      quo <= QW'(DIVIDEND);
    end else if (st.divStep) begin
      if (trial >= {1'b0, sum}) begin
        rem <= SUM_W'(trial - {1'b0, sum});
        quo <= {quo[QW-2:0], 1'b1};
      end else begin
        rem <= SUM_W'(trial);
        quo <= {quo[QW-2:0], 1'b0};
      end
    end
  end

  assign factor = (sum == '0) ? '0 : quo;

  // ---------------- normalisation ----------------
  genvar gl;
  generate
    for (gl = 0; gl < GROUP_W; gl++) begin : gLane
      logic signed [7:0] x;
      logic signed [8:0] d;
      logic [3:0]        sh;
      logic [QW-1:0]     v;
      assign x  = rowBuf[int'(slot) * GROUP_W + gl];
      assign d  = {runMax[7], runMax} - {x[7], x};
      assign sh = expShift(d[7:0]);
      assign v  = (sh >= 4'd8) ? '0 : (factor >> sh);
      assign outData[gl*8 +: 8] = (v > QW'(OUT_MAX)) ? 8'(OUT_MAX) : v[7:0];
    end
  endgenerate

  // R3: a row sum never vanishes once a group has been taken
  assert_sum_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.accept |=> (sum != '0));

  // R4: the running maximum never falls within a row
  assert_max_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.accept && !st.first) |=> (runMax >= $past(runMax)));

  // R5: the factor is the floor quotient of the fixed dividend by the sum
  assert_factor_exact_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.emit && sum != '0) |->
      ((PW'(quo) * PW'(sum) <= PW'(DIVIDEND)) &&
       ((PW'(quo) + PW'(1)) * PW'(sum) > PW'(DIVIDEND))));

endmodule

// File: rtl/smx_stream_top.sv
module smx_stream_top
  import smx_pkg::*;
#(
  parameter int GROUP_W = 16,
  parameter int SEQ_LEN = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [GROUP_W*8-1:0] inData,
  output logic                 outValid,
  output logic [GROUP_W*8-1:0] outData
);

  localparam int NUM_GROUPS = SEQ_LEN / GROUP_W;
  localparam int GIDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int OUT_MAX    = 127;
  localparam int DIVIDEND   = OUT_MAX * 1024;
  localparam int QW         = $clog2(DIVIDEND + 1);
  localparam int SUM_W      = $clog2(SEQ_LEN * 256 + 1);

  smxStrobe_t        st;
  logic [GIDX_W-1:0] slot;

  smx_ctrl #(
    .NUM_GROUPS(NUM_GROUPS),
    .QW        (QW),
    .GIDX_W    (GIDX_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .st      (st),
    .slot    (slot)
  );

  smx_datapath #(
    .GROUP_W   (GROUP_W),
    .SEQ_LEN   (SEQ_LEN),
    .NUM_GROUPS(NUM_GROUPS),
    .SUM_W     (SUM_W),
    .QW        (QW),
    .DIVIDEND  (DIVIDEND),
    .OUT_MAX   (OUT_MAX),
    .GIDX_W    (GIDX_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .slot   (slot),
    .inData (inData),
    .outData(outData)
  );

  // R8: output beats and input acceptance never overlap
  assert_busy_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  genvar cl;
  generate
    for (cl = 0; cl < GROUP_W; cl++) begin : gCap
      // R6: every emitted value stays within the signed-safe range
      assert_out_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> (outData[cl*8 +: 8] <= 8'(OUT_MAX)));
    end
  endgenerate

endmodule

// File: tb/smx_stream_top_test.sv
module smx_stream_top_test;

  localparam int GW         = 16;
  localparam int SEQ        = 64;
  localparam int NG         = SEQ / GW;
  localparam int DIV_CYCLES = 18;
  localparam int WATCHDOG   = 100000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic [GW*8-1:0] inData = '0;
  logic            inReady;
  logic            outValid;
  logic [GW*8-1:0] outData;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int seed = 32'h1234_5678;

  int rowVals [SEQ];
  int expVals [SEQ];

  logic [GW*8-1:0] qData [$];
  int              qCyc  [$];
  string           qTag  [$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smx_stream_top #(.GROUP_W(GW), .SEQ_LEN(SEQ)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  function automatic int esh(input int d);
    return d / 32 + (((d % 32) >= 16) ? 1 : 0);
  endfunction

  // Reference from the requirements (R3, R4, R5, R6)
  function automatic void model();
    int mx, s, f, gm, sh, v;
    mx = 0; s = 0;
    for (int g = 0; g < NG; g++) begin
      gm = rowVals[g*GW];
      for (int l = 1; l < GW; l++) if (rowVals[g*GW+l] > gm) gm = rowVals[g*GW+l];
      if (g == 0) begin
        mx = gm; s = 0;
      end else if (gm > mx) begin
        s = s >> esh(gm - mx);
        mx = gm;
      end
      for (int l = 0; l < GW; l++) begin
        sh = esh(mx - rowVals[g*GW+l]);
        if (sh < 8) s = s + (256 >> sh);
      end
    end
    f = (s == 0) ? 0 : 130048 / s;
    for (int i = 0; i < SEQ; i++) begin
      sh = esh(mx - rowVals[i]);
      v = (sh >= 8) ? 0 : (f >> sh);
      expVals[i] = (v > 127) ? 127 : v;
    end
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32'h7fff;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [GW*8-1:0] got, input logic [GW*8-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // Driver (R2): send one row, back to back, then queue its expected beats
  task automatic sendRow(input string tag);
    int lastC;
    logic [GW*8-1:0] e;
    for (int g = 0; g < NG; g++) begin
      @(negedge clk);
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      for (int l = 0; l < GW; l++) inData[l*8 +: 8] = 8'(rowVals[g*GW+l]);
    end
    lastC = cyc;
    model();
    for (int g = 0; g < NG; g++) begin
      for (int l = 0; l < GW; l++) e[l*8 +: 8] = 8'(expVals[g*GW+l]);
      qData.push_back(e);
      qCyc.push_back(lastC + DIV_CYCLES + 1 + g);
      qTag.push_back(tag);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // R8: beats offered while busy must be dropped
  task automatic junk(input int n);
    for (int k = 0; k < n; k++) begin
      if (!inReady) begin
        inValid = 1'b1;
        for (int l = 0; l < GW; l++) inData[l*8 +: 8] = 8'(rnd());
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  // Monitor: R6 values, R7 timing and order
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qData.size() == 0) begin
        check(1'b0, "R7", "unexpected beat", outData, '0);
      end else begin
        logic [GW*8-1:0] e;
        int c;
        string t;
        e = qData.pop_front();
        c = qCyc.pop_front();
        t = qTag.pop_front();
        check(outData === e, {t, " R6"}, "data", outData, e);
        check(cyc == c, {t, " R7"}, "beat cycle", GW*8'(cyc), GW*8'(c));
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R7 got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset values
    check(inReady === 1'b1, "R1", "inReady in reset", GW*8'(inReady), GW*8'(1));
    check(outValid === 1'b0, "R1", "outValid in reset", GW*8'(outValid), GW*8'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(inReady === 1'b1, "R1", "inReady after reset", GW*8'(inReady), GW*8'(1));
    check(outValid === 1'b0, "R1", "outValid after reset", GW*8'(outValid), GW*8'(0));

    // R3 R5: flat row, sum 16384, factor 7
    for (int i = 0; i < SEQ; i++) rowVals[i] = 0;
    sendRow("R3_flat");

    // R6: one peak, all others far below
    for (int i = 0; i < SEQ; i++) rowVals[i] = -128;
    rowVals[37] = 100;
    sendRow("R6_peak");

    // R4: maximum rising every group
    for (int i = 0; i < SEQ; i++) rowVals[i] = ((i / GW) * 40 + (i % GW) > 127) ? 127 : (i / GW) * 40 + (i % GW);
    sendRow("R4_rise");

    // R4: maximum falling every group
    for (int i = 0; i < SEQ; i++) rowVals[i] = 120 - (i / GW) * 40 + (i % GW) - 15;
    sendRow("R4_fall");

    // R4: full-range jump, rescale of 8 places
    for (int i = 0; i < SEQ; i++) rowVals[i] = (i < GW) ? -128 : -100;
    rowVals[GW + 3] = 127;
    sendRow("R4_jump");

    // R4: later group only ties the maximum
    for (int i = 0; i < SEQ; i++) rowVals[i] = 10 + (i % 7);
    rowVals[2] = 50; rowVals[2*GW + 9] = 50;
    sendRow("R4_tie");

    // R3: differences at the rounding edges 15/16 and 47/48
    for (int i = 0; i < SEQ; i++) begin
      case (i % 5)
        0: rowVals[i] = 100;
        1: rowVals[i] = 85;
        2: rowVals[i] = 84;
        3: rowVals[i] = 53;
        default: rowVals[i] = 52;
      endcase
    end
    sendRow("R3_round");

    // R2 R6: random wide rows
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < SEQ; i++) rowVals[i] = (rnd() & 255) - 128;
      sendRow("R2_wide");
    end

    // R5 R6: random narrow rows (large sums, small outputs)
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < SEQ; i++) rowVals[i] = (rnd() & 31) - 10;
      sendRow("R5_narrow");
    end

    // R8: junk while busy, then another row
    for (int i = 0; i < SEQ; i++) rowVals[i] = (i * 13) % 90 - 45;
    sendRow("R8_busy");
    junk(10);
    for (int i = 0; i < SEQ; i++) rowVals[i] = 64 - (i * 3) % 70;
    sendRow("R8_next");

    while (qData.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R7: engine idle again and ready
    check(inReady === 1'b1 && outValid === 1'b0, "R7", "idle after rows",
          GW*8'({inReady, outValid}), GW*8'(2));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule